// File: doc/BRIEF.md
# Serialized Interrupt Host Decoder

This block is the host end of a shared, single-wire interrupt line. Peripherals on the line do not have their own request pins. Each one pulls the wire low during its own time slot instead. The host opens every frame with a long low pulse. It then releases the wire and counts clocks. Each slot is three clocks long: one sample clock followed by two turnaround clocks. Whatever level the wire has on a slot's sample clock becomes that slot's interrupt level. The last slot of a frame carries the non-maskable interrupt. All other slots map in order onto a vector of interrupt levels.

The host ends each frame with a short low stop pulse. The length of that pulse announces what happens next:

- **Continuous operation:** the host alone opens the next frame, after a fixed idle gap.
- **Quiet operation:** the host leaves the wire alone until a peripheral pulls it low for a single clock. The host then holds the wire low for the rest of a start pulse.

The interrupt vector and the NMI level are refreshed together, once per frame, at the end of the frame. A slot that is sampled high clears its interrupt. The line drive output is meant for an open-drain pad outside this block, and the line input is the already synchronized wire level.

Top module: `serirq_host`

## Requirements
- R1: While reset is held, `serirq_drive`, `irq_level` and `nmi_level` are all 0. After reset the block is in continuous operation.
- R2: In continuous operation the host opens a frame by holding `serirq_drive` high for exactly START_LEN (default 8) consecutive clocks.
- R3: Frame clock f counts from 0 on the first clock after the start pulse. The wire read low at f = 3*i asserts slot i, and read high deasserts it. The wire level on clocks with f mod 3 equal to 1 or 2 has no effect. `serirq_drive` stays 0 throughout the slots.
- R4: With N slots, slots 0 to N-2 drive `irq_level[0]` to `irq_level[N-2]`, and slot N-1 drives `nmi_level`. Bits of `irq_level` at index N-1 and above read 0. N is the value of `slot_count` on the last start-pulse clock, and it must lie in 2..MAX_SLOTS (default 17).
- R5: After the 3*N slot clocks, the host drives a stop pulse and then releases the wire for 2 turnaround clocks. The stop pulse lasts 3 clocks when `quiet_sel` is 0 during the last slot clock, and 2 clocks when it is 1.
- R6: After a 3-clock stop pulse, the next start pulse begins exactly IDLE_GAP (default 4) clocks after the last turnaround clock. A low wire during that gap has no effect on its length.
- R7: After a 2-clock stop pulse, the host keeps `serirq_drive` at 0 until it reads the wire low for one clock. From the next clock it drives the wire low for START_LEN-1 clocks, and the slots then follow as in R3.
- R8: `irq_level` and `nmi_level` change only at the clock edge that ends the second turnaround clock. At that edge every slot of the frame is refreshed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serirq_in | input | 1 | Synchronized level of the shared wire (0 = low) |
| quiet_sel | input | 1 | 1 selects quiet operation after the current frame, 0 selects continuous |
| slot_count | input | $clog2(MAX_SLOTS+1) | Number of slots per frame, NMI slot included |
| serirq_drive | output | 1 | 1 pulls the wire low through the external open-drain pad |
| irq_level | output | MAX_SLOTS-1 | Latched interrupt levels, bit i from slot i |
| nmi_level | output | 1 | Latched level of the final slot |

## Verification
The assertions assume that `slot_count` stays within 2..MAX_SLOTS. They also assume that the wire reflects the host's own drive together with any peripheral pulls, with no further delay. The bench keeps to both assumptions. It picks slot counts only from the legal range. It models the wire as the AND of the host drive and one peripheral pull, which it times by watching `serirq_drive`. Turnaround noise and idle-time pulses are injected only where the requirements say they have no effect, or where they serve as a quiet-mode start request.

// File: rtl/serirq_pkg.sv
package serirq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_SLOT,
    SQ_STOP,
    SQ_TAR
  } sq_state_e;
endpackage

// File: rtl/serirq_seq.sv
module serirq_seq
  import serirq_pkg::*;
#(
  parameter int START_LEN = 8,
  parameter int IDLE_GAP  = 4,
  parameter int MAX_SLOTS = 17,
  localparam int SW = $clog2(MAX_SLOTS + 1),
  localparam int CW = $clog2(START_LEN + IDLE_GAP + 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  input  logic          mode_quiet,
  input  logic [SW-1:0] num_slots,
  output logic          drive_low,
  output logic          sample_stb,
  output logic [SW-1:0] slot_idx,
  output logic [SW-1:0] n_lat,
  output logic          frame_done
);
  sq_state_e     st;
  logic [CW-1:0] cnt;
  logic [1:0]    phase;
  logic          quiet_q;
  logic          last_slot;

  assign last_slot  = (slot_idx == n_lat - SW'(1));
  assign drive_low  = (st == SQ_START) || (st == SQ_STOP);
  assign sample_stb = (st == SQ_SLOT) && (phase == 2'd0);
  assign frame_done = (st == SQ_TAR) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= CW'(IDLE_GAP - 1);
      phase    <= '0;
      slot_idx <= '0;
      n_lat    <= SW'(2);
      quiet_q  <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (quiet_q) begin
            if (!line_in) begin
              st  <= SQ_START;
              cnt <= CW'(START_LEN - 2);
            end
          end else if (cnt == '0) begin
            st  <= SQ_START;
            cnt <= CW'(START_LEN - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SQ_START: begin
          if (cnt == '0) begin
            st       <= SQ_SLOT;
            slot_idx <= '0;
            phase    <= '0;
            n_lat    <= num_slots;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SQ_SLOT: begin
          if (phase == 2'd2) begin
            phase <= '0;
            if (last_slot) begin
              st      <= SQ_STOP;
              quiet_q <= mode_quiet;
              cnt     <= mode_quiet ? CW'(1) : CW'(2);
            end else begin
              slot_idx <= slot_idx + SW'(1);
            end
          end else begin
            phase <= phase + 2'd1;
          end
        end
        SQ_STOP: begin
          if (cnt == '0) begin
            st  <= SQ_TAR;
            cnt <= CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SQ_TAR: begin
          if (cnt == '0) begin
            st  <= SQ_IDLE;
            cnt <= CW'(IDLE_GAP - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R4: slot count input kept in its legal range when latched
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_START && cnt == '0) |-> (num_slots >= SW'(2) && num_slots <= SW'(MAX_SLOTS)));

  // R7: a low wire in quiet idle opens a frame on the next clock
  a_r7_quiet_request: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && quiet_q && !line_in) |=> drive_low);

  // R7: without a request, quiet idle stays idle
  a_r7_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && quiet_q && line_in) |=> !drive_low);

  // R6: continuous idle is not shortened by the wire
  a_r6_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && !quiet_q && cnt != '0) |=> (st == SQ_IDLE));

  // R5: the stop pulse follows only the last slot
  a_r5_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == SQ_STOP) |-> ($past(slot_idx) == $past(n_lat) - SW'(1)));
endmodule

// File: rtl/serirq_capture.sv
module serirq_capture #(
  parameter int MAX_SLOTS = 17,
  localparam int SW   = $clog2(MAX_SLOTS + 1),
  localparam int NIRQ = MAX_SLOTS - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_in,
  input  logic            sample_stb,
  input  logic [SW-1:0]   slot_idx,
  input  logic [SW-1:0]   n_lat,
  input  logic            frame_done,
  output logic [NIRQ-1:0] irq_level,
  output logic            nmi_level
);
  logic [SW-1:0] nmi_idx;
  logic          shadow_nmi;
  assign nmi_idx = n_lat - SW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_nmi <= 1'b0;
      nmi_level  <= 1'b0;
    end else begin
      if (sample_stb && slot_idx == nmi_idx) shadow_nmi <= !line_in;
      if (frame_done) nmi_level <= shadow_nmi;
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_slot
    logic shadow;
    logic in_use;
    assign in_use = (SW'(i) < nmi_idx);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow       <= 1'b0;
        irq_level[i] <= 1'b0;
      end else begin
        if (sample_stb && slot_idx == SW'(i) && in_use) shadow <= !line_in;
        if (frame_done) irq_level[i] <= in_use ? shadow : 1'b0;
      end
    end
  end

  // R8: levels move only at the end of a frame
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable({irq_level, nmi_level}));

  // R3: sampling happens only inside the frame's slot range
  a_r3_sample_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (slot_idx < n_lat));
endmodule

// File: rtl/serirq_host.sv
module serirq_host #(
  parameter int START_LEN = 8,
  parameter int IDLE_GAP  = 4,
  parameter int MAX_SLOTS = 17,
  localparam int SW   = $clog2(MAX_SLOTS + 1),
  localparam int NIRQ = MAX_SLOTS - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            serirq_in,
  input  logic            quiet_sel,
  input  logic [SW-1:0]   slot_count,
  output logic            serirq_drive,
  output logic [NIRQ-1:0] irq_level,
  output logic            nmi_level
);
  logic          sample_stb;
  logic          frame_done;
  logic [SW-1:0] slot_idx;
  logic [SW-1:0] n_lat;

  serirq_seq #(
    .START_LEN (START_LEN),
    .IDLE_GAP  (IDLE_GAP),
    .MAX_SLOTS (MAX_SLOTS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (serirq_in),
    .mode_quiet (quiet_sel),
    .num_slots  (slot_count),
    .drive_low  (serirq_drive),
    .sample_stb (sample_stb),
    .slot_idx   (slot_idx),
    .n_lat      (n_lat),
    .frame_done (frame_done)
  );

  serirq_capture #(
    .MAX_SLOTS (MAX_SLOTS)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (serirq_in),
    .sample_stb (sample_stb),
    .slot_idx   (slot_idx),
    .n_lat      (n_lat),
    .frame_done (frame_done),
    .irq_level  (irq_level),
    .nmi_level  (nmi_level)
  );

  // R3: the host never pulls the wire during a sample clock
  a_r3_released_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !serirq_drive);
endmodule

// File: tb/serirq_host_bench.sv
module serirq_host_bench;
  localparam int START_LEN = 8;
  localparam int IDLE_GAP  = 4;
  localparam int MAX_SLOTS = 17;
  localparam int SW   = $clog2(MAX_SLOTS + 1);
  localparam int NIRQ = MAX_SLOTS - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_low = 1'b0;
  logic quiet_sel = 1'b0;
  logic [SW-1:0] slot_count = SW'(MAX_SLOTS);
  logic serirq_in;
  logic serirq_drive;
  logic [NIRQ-1:0] irq_level;
  logic nmi_level;

  int errs = 0;
  int checks = 0;
  bit cur_quiet = 1'b0;
  logic [NIRQ-1:0] prev_vec = '0;
  logic prev_nmi = 1'b0;

  always #5 clk = ~clk;
  assign serirq_in = !(serirq_drive || dev_low);

  serirq_host #(
    .START_LEN (START_LEN),
    .IDLE_GAP  (IDLE_GAP),
    .MAX_SLOTS (MAX_SLOTS)
  ) u_serirq_host (
    .clk          (clk),
    .rst_n        (rst_n),
    .serirq_in    (serirq_in),
    .quiet_sel    (quiet_sel),
    .slot_count   (slot_count),
    .serirq_drive (serirq_drive),
    .irq_level    (irq_level),
    .nmi_level    (nmi_level)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NIRQ-1:0] mask_vec(input logic [NIRQ-1:0] v, input int n);
    logic [NIRQ-1:0] m;
    for (int i = 0; i < NIRQ; i++) m[i] = (i < n - 1) ? v[i] : 1'b0;
    return m;
  endfunction

  // Entered at a negedge in an idle clock; leaves at the first idle negedge after the frame.
  task automatic do_frame(input logic [NIRQ-1:0] irqs, input bit nmib, input int n,
                          input bit q_next, input bit noise, input bit first);
    int c;
    bit drove;
    slot_count = SW'(n);
    if (cur_quiet) begin
      int w = $urandom_range(0, 5);
      for (int k = 0; k < w; k++) begin
        @(negedge clk);
        chk(!serirq_drive, "R7", "quiet idle host silent", serirq_drive, 0);
      end
      dev_low = 1'b1;
      @(negedge clk);
      dev_low = 1'b0;
      c = 0;
      while (serirq_drive && c < 100) begin c++; @(negedge clk); end
      chk(c == START_LEN - 1, "R7", "host start length after request", c, START_LEN - 1);
    end else begin
      if (!first && noise) dev_low = 1'b1;
      c = 1;
      while (c < 1000) begin
        @(negedge clk);
        dev_low = 1'b0;
        if (serirq_drive) break;
        c++;
      end
      if (!first) chk(c == IDLE_GAP, "R6", "idle gap length", c, IDLE_GAP);
      c = 0;
      while (serirq_drive && c < 100) begin c++; @(negedge clk); end
      chk(c == START_LEN, "R2", "start pulse length", c, START_LEN);
    end
    quiet_sel = q_next;
    chk(irq_level == prev_vec && nmi_level == prev_nmi, "R8", "levels held at slot 0",
        {nmi_level, irq_level}, {prev_nmi, prev_vec});
    drove = 1'b0;
    for (int f = 0; f < 3 * n; f++) begin
      if (f > 0) @(negedge clk);
      if (serirq_drive) drove = 1'b1;
      if (f % 3 == 0) dev_low = (f / 3 < n - 1) ? irqs[f / 3] : nmib;
      else dev_low = noise ? 1'($urandom_range(0, 1)) : 1'b0;
    end
    @(negedge clk);
    dev_low = 1'b0;
    chk(!drove, "R3", "host silent during slots", drove, 0);
    c = 0;
    while (serirq_drive && c < 10) begin c++; @(negedge clk); end
    chk(c == (q_next ? 2 : 3), "R5", "stop pulse length", c, q_next ? 2 : 3);
    @(negedge clk);
    chk(!serirq_drive, "R5", "second turnaround released", serirq_drive, 0);
    chk(irq_level == prev_vec && nmi_level == prev_nmi, "R8", "levels held in turnaround",
        {nmi_level, irq_level}, {prev_nmi, prev_vec});
    @(negedge clk);
    chk(irq_level == mask_vec(irqs, n), n < MAX_SLOTS ? "R4" : "R3", "irq levels after frame",
        irq_level, mask_vec(irqs, n));
    chk(nmi_level == nmib, "R4", "nmi level after frame", nmi_level, nmib);
    prev_vec  = mask_vec(irqs, n);
    prev_nmi  = nmib;
    cur_quiet = q_next;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!serirq_drive && irq_level == '0 && !nmi_level, "R1", "reset state",
        {serirq_drive, nmi_level, irq_level}, 0);
    rst_n = 1'b1;
    do_frame(16'h0000, 1'b0, 17, 1'b0, 1'b0, 1'b1);
    do_frame(16'hFFFF, 1'b1, 17, 1'b0, 1'b1, 1'b0);
    do_frame(16'hA5A5, 1'b0, 17, 1'b1, 1'b1, 1'b0);
    do_frame(16'hFFFF, 1'b1, 2, 1'b1, 1'b0, 1'b0);
    do_frame(16'h8000, 1'b0, 17, 1'b0, 1'b1, 1'b0);
    do_frame(16'hFFFF, 1'b1, 5, 1'b0, 1'b0, 1'b0);
    for (int r = 0; r < 30; r++) begin
      do_frame(16'($urandom()), 1'($urandom_range(0, 1)), $urandom_range(2, MAX_SLOTS),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule